// File: doc/BRIEF.md
# Converter Register Front End

This block is the register front end of a successive-approximation converter controller. It sits on a simple 32-bit word-addressed register bus and turns register writes into conversion and calibration requests for an external sequencer. The sequencer returns each finished sample, and the front end keeps it in a result register. A completion flag records each finished sample, and an interrupt line follows that flag.

Software writes a channel number into the first channel-control register to start a conversion. Writing the all-ones channel code stops conversion instead. A continuous mode issues the next request on the same channel after each completion. A calibration command bit in the general control register launches a calibration run and clears itself when the run ends. A separate status bit reports a calibration that was disturbed by a channel-control write.

The request side is a valid/ready stream. `req_valid` stays high and `req_chan` and `req_cal` stay unchanged until the sequencer takes the request with `req_ready`. The return side has no ready signal: the front end accepts a `done_valid` pulse in any cycle and never applies back-pressure. A pulse that arrives while no request is outstanding is discarded.

Top module: `sar_ctl_regs`

## Requirements
- R1: After reset, the channel-control register at 0x00 reads 0x1F. Every other register reads 0, and `irq` and `req_valid` are low.
- R2: A write to 0x00 with bits [4:0] not equal to 0x1F raises `req_valid` on the next cycle, with `req_chan` equal to the written channel and `req_cal` low. The request is held unchanged until `req_ready` is high.
- R3: A returned sample is stored in the result register at 0x0C after masking to the resolution in configuration bits [3:2] (register 0x14): 00 keeps 8 bits, 01 keeps 10 bits, and 10 or 11 keeps 12 bits. Bit 0 of the status register at 0x08 is then set.
- R4: `irq` is high exactly when status bit 0 is set and bit 7 of the channel-control register is set.
- R5: A read of the result register at 0x0C clears status bit 0.
- R6: With configuration bit 16 set, a new sample replaces an unread one. With bit 16 clear, a sample that arrives while status bit 0 is set is dropped, and the result register keeps its old value.
- R7: With general-control bit 6 set (register 0x18), the next request on the same channel is raised on the cycle after each completion. A write of channel 0x1F drops `req_valid` on the next cycle, and no further request follows.
- R8: Writing general-control bit 7 raises a request with `req_cal` high and `req_chan` 0x1F. Bit 7 reads 1 until the calibration sample returns and 0 afterwards. The return sets status bit 0.
- R9: A write to 0x00 while a calibration runs sets bit 1 of the general status register at 0x1C when the calibration ends. Starting the next calibration clears that bit.
- R10: An access at an address that is not word aligned or lies above 0x30 raises `bus_err`, reads 0 and changes no register. Offsets 0x20 to 0x30 read 0 and raise no error.
- R11: Read-back: general-control bits 0, 1, 5 and 6 hold their written values; channel-control registers at 0x00 and 0x04 keep bits 7 and [4:0]; the configuration register keeps bits [16:0]. All other bits read 0.
- R12: A `done_valid` pulse that arrives when no conversion is outstanding changes neither the result register nor the status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W (8) | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| bus_err | output | 1 | Access is misaligned or out of range |
| irq | output | 1 | Completion interrupt |
| req_valid | output | 1 | Request to the sequencer is pending |
| req_ready | input | 1 | Sequencer takes the request |
| req_chan | output | CH_W (5) | Channel to convert, 0x1F for calibration |
| req_cal | output | 1 | Request is a calibration run |
| done_valid | input | 1 | Sequencer returns a sample |
| done_data | input | RES_W (12) | Returned raw sample |

## Verification
Most internal faults in this block show up at the ports within one or two cycles. A sequencer that enters the wrong state shows as `req_valid` not rising, or as a request that does not repeat in continuous mode, on the cycle after the write or the completion. A wrong completion flag or a wrong overwrite decision shows at the next read of the result and status registers. A wrong resolution mask shows as high bits that should be zero. Calibration faults are visible in the command bit read-back while the calibration runs and in the failure bit at its end.

// File: rtl/sar_ctl_pkg.sv
package sar_ctl_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_REQ  = 2'd1,
    SQ_WAIT = 2'd2
  } seq_st_t;

  typedef enum logic [3:0] {
    SEL_HC0, SEL_HC1, SEL_HS, SEL_R0, SEL_R1,
    SEL_CFG, SEL_GC, SEL_GS, SEL_ZERO
  } reg_sel_t;

  localparam int LAST_OFS    = 'h30;
  localparam int CFG_W       = 17;
  localparam int CFG_OVW_BIT = 16;
  localparam int HC_IE_BIT   = 7;
  localparam int GC_ACLK_BIT = 0;
  localparam int GC_DMA_BIT  = 1;
  localparam int GC_AVG_BIT  = 5;
  localparam int GC_CONT_BIT = 6;
  localparam int GC_CAL_BIT  = 7;
  localparam int GS_FAIL_BIT = 1;

endpackage

// File: rtl/sar_ctl_decode.sv
module sar_ctl_decode
  import sar_ctl_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_t          sel,
  output logic              err
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic             misaligned;
  logic             beyond;

  assign idx        = addr[ADDR_W-1:2];
  assign misaligned = |addr[1:0];
  assign beyond     = 32'(addr) > 32'(LAST_OFS);
  assign err        = misaligned | beyond;

  always_comb begin
    case (idx)
      IDX_W'(0): sel = SEL_HC0;
      IDX_W'(1): sel = SEL_HC1;
      IDX_W'(2): sel = SEL_HS;
      IDX_W'(3): sel = SEL_R0;
      IDX_W'(4): sel = SEL_R1;
      IDX_W'(5): sel = SEL_CFG;
      IDX_W'(6): sel = SEL_GC;
      IDX_W'(7): sel = SEL_GS;
      default:   sel = SEL_ZERO;
    endcase
  end
endmodule

// File: rtl/sar_ctl_seq.sv
module sar_ctl_seq
  import sar_ctl_pkg::*;
#(
  parameter int CH_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hc0_wr,
  input  logic [CH_W-1:0] hc0_wchan,
  input  logic [CH_W-1:0] cur_chan,
  input  logic            gc_cal_wr,
  input  logic            cont_en,
  input  logic            req_ready,
  input  logic            done_valid,
  output logic            req_valid,
  output logic            req_cal,
  output logic [CH_W-1:0] req_chan,
  output logic            conv_fire,
  output logic            cal_fire,
  output logic            cal_q,
  output logic            calf_q
);
  localparam logic [CH_W-1:0] STOP_CODE = '1;

  seq_st_t st_q;
  logic    abort_q;
  logic    cal_start;
  logic    restart_wr;
  logic    waiting;

  assign cal_start  = gc_cal_wr & ~cal_q;
  assign restart_wr = hc0_wr & ~cal_q;
  assign waiting    = (st_q == SQ_WAIT) & done_valid;
  assign conv_fire  = waiting & ~cal_q & ~restart_wr & ~cal_start;
  assign cal_fire   = waiting & cal_q;

  assign req_valid = (st_q == SQ_REQ);
  assign req_cal   = cal_q;
  assign req_chan  = cal_q ? STOP_CODE : cur_chan;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= SQ_IDLE;
      cal_q   <= 1'b0;
      abort_q <= 1'b0;
      calf_q  <= 1'b0;
    end else begin
      if (cal_start) begin
        st_q    <= SQ_REQ;
        cal_q   <= 1'b1;
        abort_q <= 1'b0;
        calf_q  <= 1'b0;
      end else if (restart_wr) begin
        st_q <= (hc0_wchan == STOP_CODE) ? SQ_IDLE : SQ_REQ;
      end else if (st_q == SQ_REQ && req_ready) begin
        st_q <= SQ_WAIT;
      end else if (cal_fire) begin
        st_q   <= SQ_IDLE;
        cal_q  <= 1'b0;
        calf_q <= abort_q;
      end else if (conv_fire) begin
        st_q <= (cont_en && cur_chan != STOP_CODE) ? SQ_REQ : SQ_IDLE;
      end
      if (hc0_wr && cal_q) abort_q <= 1'b1;
    end
  end
endmodule

// File: rtl/sar_ctl_result.sv
module sar_ctl_result #(
  parameter int RES_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv_fire,
  input  logic             cal_fire,
  input  logic [RES_W-1:0] raw,
  input  logic [1:0]       res_mode,
  input  logic             ovw_en,
  input  logic             r0_rd,
  output logic [RES_W-1:0] r0_q,
  output logic             coco,
  output logic             store
);
  localparam int W_LO  = RES_W - 4;
  localparam int W_MID = RES_W - 2;

  logic [7:0]       eff_w;
  logic [RES_W-1:0] mask;

  always_comb begin
    case (res_mode)
      2'b00:   eff_w = 8'(W_LO);
      2'b01:   eff_w = 8'(W_MID);
      default: eff_w = 8'(RES_W);
    endcase
  end

  for (genvar b = 0; b < RES_W; b++) begin : g_mask
    assign mask[b] = 8'(b) < eff_w;
  end

  assign store = conv_fire & (~coco | ovw_en);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r0_q <= '0;
      coco <= 1'b0;
    end else begin
      if (store) r0_q <= raw & mask;
      if (store || cal_fire) coco <= 1'b1;
      else if (r0_rd)        coco <= 1'b0;
    end
  end
endmodule

// File: rtl/sar_ctl_regs.sv
module sar_ctl_regs
  import sar_ctl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CH_W   = 5,
  parameter int RES_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_err,
  output logic              irq,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [CH_W-1:0]   req_chan,
  output logic              req_cal,
  input  logic              done_valid,
  input  logic [RES_W-1:0]  done_data
);
  reg_sel_t         sel;
  logic             wr_ok, rd_ok;
  logic             hc0_wr, rd_r0;
  logic             hc0_ie, hc1_ie;
  logic [CH_W-1:0]  hc0_chan, hc1_chan;
  logic [CFG_W-1:0] cfg_q;
  logic             gc_aclk, gc_dma, gc_avg, gc_cont;
  logic             conv_fire, cal_fire, cal_q, calf_q;
  logic [RES_W-1:0] r0_q;
  logic             coco, store;
  logic             unused_wdata;

  assign unused_wdata = ^bus_wdata[31:CFG_W];

  sar_ctl_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .sel  (sel),
    .err  (bus_err)
  );

  assign wr_ok  = bus_en & bus_we & ~bus_err;
  assign rd_ok  = bus_en & ~bus_we & ~bus_err;
  assign hc0_wr = wr_ok & (sel == SEL_HC0);
  assign rd_r0  = rd_ok & (sel == SEL_R0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hc0_ie   <= 1'b0;
      hc0_chan <= '1;
      hc1_ie   <= 1'b0;
      hc1_chan <= '0;
      cfg_q    <= '0;
      gc_aclk  <= 1'b0;
      gc_dma   <= 1'b0;
      gc_avg   <= 1'b0;
      gc_cont  <= 1'b0;
    end else if (wr_ok) begin
      case (sel)
        SEL_HC0: begin
          hc0_ie   <= bus_wdata[HC_IE_BIT];
          hc0_chan <= bus_wdata[CH_W-1:0];
        end
        SEL_HC1: begin
          hc1_ie   <= bus_wdata[HC_IE_BIT];
          hc1_chan <= bus_wdata[CH_W-1:0];
        end
        SEL_CFG: cfg_q <= bus_wdata[CFG_W-1:0];
        SEL_GC: begin
          gc_aclk <= bus_wdata[GC_ACLK_BIT];
          gc_dma  <= bus_wdata[GC_DMA_BIT];
          gc_avg  <= bus_wdata[GC_AVG_BIT];
          gc_cont <= bus_wdata[GC_CONT_BIT];
        end
        default: ;
      endcase
    end
  end

  sar_ctl_seq #(.CH_W(CH_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .hc0_wr     (hc0_wr),
    .hc0_wchan  (bus_wdata[CH_W-1:0]),
    .cur_chan   (hc0_chan),
    .gc_cal_wr  (wr_ok & (sel == SEL_GC) & bus_wdata[GC_CAL_BIT]),
    .cont_en    (gc_cont),
    .req_ready  (req_ready),
    .done_valid (done_valid),
    .req_valid  (req_valid),
    .req_cal    (req_cal),
    .req_chan   (req_chan),
    .conv_fire  (conv_fire),
    .cal_fire   (cal_fire),
    .cal_q      (cal_q),
    .calf_q     (calf_q)
  );

  sar_ctl_result #(.RES_W(RES_W)) u_res (
    .clk       (clk),
    .rst_n     (rst_n),
    .conv_fire (conv_fire),
    .cal_fire  (cal_fire),
    .raw       (done_data),
    .res_mode  (cfg_q[3:2]),
    .ovw_en    (cfg_q[CFG_OVW_BIT]),
    .r0_rd     (rd_r0),
    .r0_q      (r0_q),
    .coco      (coco),
    .store     (store)
  );

  assign irq = coco & hc0_ie;

  always_comb begin
    bus_rdata = '0;
    if (!bus_err) begin
      case (sel)
        SEL_HC0: begin
          bus_rdata[HC_IE_BIT]  = hc0_ie;
          bus_rdata[CH_W-1:0]   = hc0_chan;
        end
        SEL_HC1: begin
          bus_rdata[HC_IE_BIT]  = hc1_ie;
          bus_rdata[CH_W-1:0]   = hc1_chan;
        end
        SEL_HS:  bus_rdata[0] = coco;
        SEL_R0:  bus_rdata[RES_W-1:0] = r0_q;
        SEL_CFG: bus_rdata[CFG_W-1:0] = cfg_q;
        SEL_GC: begin
          bus_rdata[GC_ACLK_BIT] = gc_aclk;
          bus_rdata[GC_DMA_BIT]  = gc_dma;
          bus_rdata[GC_AVG_BIT]  = gc_avg;
          bus_rdata[GC_CONT_BIT] = gc_cont;
          bus_rdata[GC_CAL_BIT]  = cal_q;
        end
        SEL_GS:  bus_rdata[GS_FAIL_BIT] = calf_q;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sar_ctl_regs_chk.sv
module sar_ctl_regs_chk #(
  parameter int CH_W  = 5,
  parameter int RES_W = 12,
  parameter int CFG_W = 17
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_en,
  input logic             bus_we,
  input logic             bus_err,
  input logic [31:0]      bus_wdata,
  input logic             req_valid,
  input logic             req_ready,
  input logic [CH_W-1:0]  req_chan,
  input logic             req_cal,
  input logic             store,
  input logic [CFG_W-1:0] cfg_q,
  input logic [RES_W-1:0] r0_q,
  input logic             coco,
  input logic             rd_r0,
  input logic             conv_fire,
  input logic             cal_fire,
  input logic             hc0_wr,
  input logic [CH_W-1:0]  hc0_chan,
  input logic             cal_q
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready && !bus_en |=> req_valid && $stable(req_chan)); // R2

  AST_MASK_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    store && cfg_q[3:2] == 2'b00 |=> r0_q[RES_W-1:RES_W-4] == '0); // R3

  AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_r0 && !store && !cal_fire |=> !coco); // R5

  AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_fire && coco && !cfg_q[16] |=> $stable(r0_q)); // R6

  AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    hc0_wr && bus_wdata[CH_W-1:0] == '1 && !cal_q |=> !req_valid); // R7

  AST_CAL_CHAN: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_cal |-> req_chan == '1); // R8

  AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_en && bus_we && bus_err |=> $stable(cfg_q) && $stable(hc0_chan)); // R10
endmodule

bind sar_ctl_regs sar_ctl_regs_chk #(.CH_W(CH_W), .RES_W(RES_W), .CFG_W(sar_ctl_pkg::CFG_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_en    (bus_en),
  .bus_we    (bus_we),
  .bus_err   (bus_err),
  .bus_wdata (bus_wdata),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_chan  (req_chan),
  .req_cal   (req_cal),
  .store     (store),
  .cfg_q     (cfg_q),
  .r0_q      (r0_q),
  .coco      (coco),
  .rd_r0     (rd_r0),
  .conv_fire (conv_fire),
  .cal_fire  (cal_fire),
  .hc0_wr    (hc0_wr),
  .hc0_chan  (hc0_chan),
  .cal_q     (cal_q)
);

// File: tb/sar_ctl_regs_bench.sv
module sar_ctl_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_err, irq, req_valid, req_cal;
  logic        req_ready = 1'b1;
  logic [4:0]  req_chan;
  logic        done_valid = 1'b0;
  logic [11:0] done_data = '0;

  int checks = 0, fails = 0;
  logic finished = 1'b0;
  logic last_err;
  logic [31:0] rv;

  always #10 clk = ~clk;

  sar_ctl_regs u_sar_ctl_regs (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .irq(irq), .req_valid(req_valid),
    .req_ready(req_ready), .req_chan(req_chan), .req_cal(req_cal),
    .done_valid(done_valid), .done_data(done_data)
  );

  // {mode[1:0], raw[11:0], expected[11:0]}
  localparam logic [25:0] VEC [6] = '{
    {2'b00, 12'hABC, 12'h0BC},
    {2'b01, 12'hABC, 12'h2BC},
    {2'b10, 12'hABC, 12'hABC},
    {2'b11, 12'hFFF, 12'hFFF},
    {2'b00, 12'h0FF, 12'h0FF},
    {2'b01, 12'h400, 12'h000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    #2 last_err = bus_err;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #2 d = bus_rdata; last_err = bus_err;
    @(negedge clk);
    bus_en = 1'b0;
  endtask

  task automatic finish_conv(input logic [11:0] d);
    @(negedge clk);
    done_valid = 1'b1; done_data = d;
    @(negedge clk);
    done_valid = 1'b0;
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(8'h00, rv); chk("R1 chan ctl", rv, 32'h1F);
    rd(8'h08, rv); chk("R1 status", rv, 0);
    rd(8'h14, rv); chk("R1 config", rv, 0);
    rd(8'h18, rv); chk("R1 gen ctl", rv, 0);
    rd(8'h1C, rv); chk("R1 gen status", rv, 0);
    chk("R1 irq", irq, 0);
    chk("R1 req_valid", req_valid, 0);

    // R2 request and hold under back-pressure
    req_ready = 1'b0;
    wr(8'h00, 32'h05);
    chk("R2 req_valid", req_valid, 1);
    chk("R2 req_chan", req_chan, 5);
    chk("R2 req_cal", req_cal, 0);
    @(negedge clk);
    chk("R2 held", {req_valid, 3'b0, req_chan}, {1'b1, 3'b0, 5'd5});
    req_ready = 1'b1;
    @(negedge clk);
    chk("R2 taken", req_valid, 0);
    finish_conv(12'h123);
    rd(8'h08, rv); chk("R3 flag set", rv, 1);
    rd(8'h0C, rv); chk("R3 8-bit mask", rv, 32'h23);
    rd(8'h08, rv); chk("R5 flag cleared", rv, 0);

    // R4 interrupt
    wr(8'h00, 32'h85);
    finish_conv(12'h0AA);
    chk("R4 irq high", irq, 1);
    rd(8'h0C, rv); chk("R4 data", rv, 32'hAA);
    chk("R5 irq low after read", irq, 0);

    // R3 table of resolution modes
    for (int i = 0; i < 6; i++) begin
      wr(8'h14, 32'h10000 | (32'(VEC[i][25:24]) << 2));
      wr(8'h00, 32'h03);
      finish_conv(VEC[i][23:12]);
      rd(8'h0C, rv); chk("R3 masked result", rv, 32'(VEC[i][11:0]));
    end

    // R6 overwrite control
    wr(8'h14, 32'h8);
    wr(8'h00, 32'h02);
    finish_conv(12'h111);
    chk("R4 irq needs enable", irq, 0);
    wr(8'h00, 32'h02);
    finish_conv(12'h222);
    rd(8'h0C, rv); chk("R6 dropped", rv, 32'h111);
    wr(8'h14, 32'h10008);
    wr(8'h00, 32'h02);
    finish_conv(12'h333);
    wr(8'h00, 32'h02);
    finish_conv(12'h444);
    rd(8'h0C, rv); chk("R6 replaced", rv, 32'h444);

    // R7 continuous, R12 stray completion
    wr(8'h18, 32'h40);
    wr(8'h00, 32'h06);
    finish_conv(12'h055);
    chk("R7 restart", {req_valid, 3'b0, req_chan}, {1'b1, 3'b0, 5'd6});
    wr(8'h00, 32'h1F);
    chk("R7 stopped", req_valid, 0);
    finish_conv(12'h777);
    chk("R7 no new request", req_valid, 0);
    rd(8'h0C, rv); chk("R12 stray ignored", rv, 32'h055);
    wr(8'h18, 32'h0);

    // R8 calibration
    wr(8'h00, 32'h9F);
    wr(8'h18, 32'h80);
    chk("R8 cal req", {req_valid, req_cal, 1'b0, req_chan}, {1'b1, 1'b1, 1'b0, 5'h1F});
    rd(8'h18, rv); chk("R8 cal bit busy", rv, 32'h80);
    finish_conv(12'h0);
    chk("R8 completion irq", irq, 1);
    rd(8'h18, rv); chk("R8 cal bit clear", rv, 0);
    rd(8'h1C, rv); chk("R8 no fail", rv, 0);
    rd(8'h0C, rv);

    // R9 calibration disturbed
    wr(8'h18, 32'h80);
    wr(8'h00, 32'h9F);
    finish_conv(12'h0);
    rd(8'h1C, rv); chk("R9 fail set", rv, 32'h2);
    rd(8'h0C, rv);
    wr(8'h18, 32'h80);
    rd(8'h1C, rv); chk("R9 fail cleared", rv, 0);
    finish_conv(12'h0);
    rd(8'h1C, rv); chk("R9 clean end", rv, 0);
    rd(8'h0C, rv);

    // R10 bus errors
    wr(8'h15, 32'h0);
    chk("R10 misaligned err", last_err, 1);
    wr(8'h34, 32'h0);
    chk("R10 range err", last_err, 1);
    rd(8'h14, rv); chk("R10 config kept", rv, 32'h10008);
    rd(8'h20, rv); chk("R10 upper reg no err", {31'b0, last_err}, 0);
    chk("R10 upper reg zero", rv, 0);
    rd(8'h30, rv); chk("R10 last offset ok", {31'b0, last_err}, 0);
    rd(8'h34, rv); chk("R10 read err", {31'b0, last_err}, 1);
    chk("R10 read zero", rv, 0);

    // R11 read-back masks
    wr(8'h18, 32'hFFFF_FF7F);
    rd(8'h18, rv); chk("R11 gen ctl", rv, 32'h63);
    chk("R11 no request", req_valid, 0);
    wr(8'h18, 32'h0);
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, rv); chk("R11 chan ctl 1", rv, 32'h9F);
    wr(8'h14, 32'hFFFF_FFFF);
    rd(8'h14, rv); chk("R11 config", rv, 32'h1FFFF);

    finished = 1'b1;
    report();
  end
endmodule